// File: doc/BRIEF.md
# Critical Load Identification Unit

This unit watches a stream of retired instructions, one per cycle, and decides for each load whether it is critical to performance. Every instruction arrives with an optional destination register, up to two optional source registers, load, branch and mispredict flags, its PC and its dynamic instruction count, which is the number of instructions retired before it. The unit remembers the most recent WIN instructions in a circular window. It also keeps a register table that names, for every architectural register, the window slot of the instruction that last wrote it. With these two structures it follows the direct and indirect dependents of up to SLOTS loads at the same time.

Each tracked load owns a tracking slot. The slot holds a dependent counter, a mispredict flag, the head load's PC and count, and the window index of the newest member of the load's list. A list closes, or matures, under any of three rules: it has too many dependents, its newest member has left the window, or it has grown too old. When a list matures, the load's PC and its critical or non-critical verdict appear on the output lane of that slot for one cycle. This output can feed a pinning or side-buffer policy for the data that critical loads use.

Top module: `crit_load_tracker`

## Requirements
- R1: While reset is held, and in the first cycle after it, every `out_valid` lane is low. After reset no load is tracked and every register-table entry is invalid.
- R2: A source operand creates a dependence only when the register's last writer, found through the register table, is still in the window and belongs to a list. If a non-member writes the register later, readers of that register no longer join the list.
- R3: An instruction joins every open list that any of its source operands depends on, so it can belong to several lists at once. Its own destination then carries all of those memberships to later readers, which makes the dependence transitive.
- R4: An accepted load opens a new list in the lowest-numbered free slot, with a dependent count of zero. Its verdict comes out on lane s, which means bit s of `out_valid` and `out_crit` and bits [s*PCW +: PCW] of `out_pc`. A slot whose list matures in the same cycle counts as free.
- R5: A list matures when its dependent count (members other than the head load) exceeds SIZE_TH. The verdict is then critical.
- R6: A list matures when the window slot that holds its newest member is overwritten by an instruction that does not join that list.
- R7: A list matures when the incoming instruction's count minus the head load's count exceeds DIST_TH.
- R8: At maturation the verdict is critical if and only if some member was a branch with the mispredict flag set, or the dependent count exceeds SIZE_TH.
- R9: When a load arrives and all SLOTS slots are busy and none of them matures, the slot whose head load is oldest is matured by force. Its verdict follows R8, and the new load takes that slot.
- R10: A verdict appears one cycle after the instruction that caused it. Cycles with `in_valid` low change nothing and produce no output. `out_crit` is low on every lane whose `out_valid` is low.
- R11: A register-table entry that points at a window slot is invalidated when that slot is overwritten, so a reader of a register whose writer is more than WIN instructions old joins nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_dst_en | input | 1 | Instruction writes a register |
| in_dst | input | $clog2(NREG) | Destination register |
| in_src0_en | input | 1 | First source is used |
| in_src0 | input | $clog2(NREG) | First source register |
| in_src1_en | input | 1 | Second source is used |
| in_src1 | input | $clog2(NREG) | Second source register |
| in_load | input | 1 | Instruction is a load |
| in_branch | input | 1 | Instruction is a branch |
| in_mispred | input | 1 | Branch was mispredicted |
| in_pc | input | PCW | Instruction PC |
| in_dic | input | DICW | Dynamic instruction count |
| out_valid | output | SLOTS | Per-slot verdict pulse |
| out_pc | output | SLOTS*PCW | Head-load PC per slot lane |
| out_crit | output | SLOTS | Per-slot critical verdict |

## Verification
The bench builds the unit with WIN=8, SLOTS=4, NREG=8, SIZE_TH=5 and DIST_TH=12. With an eight-entry window, slot departure happens after only a few instructions. A distance limit larger than the window means a list that keeps gaining members every few instructions reaches the distance rule before the departure rule. Four slots let a burst of five loads force an eviction, and eight registers make register reuse, shared operands and multi-list membership frequent under random stimulus.

// File: rtl/crit_load_tracker.sv
module crit_load_tracker #(
  parameter int WIN     = 8,
  parameter int SLOTS   = 4,
  parameter int NREG    = 8,
  parameter int PCW     = 32,
  parameter int DICW    = 32,
  parameter int SIZE_TH = 5,
  parameter int DIST_TH = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_dst_en,
  input  logic [$clog2(NREG)-1:0] in_dst,
  input  logic                    in_src0_en,
  input  logic [$clog2(NREG)-1:0] in_src0,
  input  logic                    in_src1_en,
  input  logic [$clog2(NREG)-1:0] in_src1,
  input  logic                    in_load,
  input  logic                    in_branch,
  input  logic                    in_mispred,
  input  logic [PCW-1:0]          in_pc,
  input  logic [DICW-1:0]         in_dic,
  output logic [SLOTS-1:0]        out_valid,
  output logic [SLOTS*PCW-1:0]    out_pc,
  output logic [SLOTS-1:0]        out_crit
);
  localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CW = $clog2(SIZE_TH + 2);
  localparam logic [CW-1:0]   SZ_LIM   = CW'(SIZE_TH);
  localparam logic [DICW-1:0] DIST_LIM = DICW'(DIST_TH);

  logic [WW-1:0]       wp;
  logic [WIN-1:0]      occ;
  logic [SLOTS-1:0]    mem [WIN];
  logic [NREG-1:0]     tv;
  logic [WW-1:0]       tag [NREG];
  logic [SLOTS-1:0]    act, mis;
  logic [SLOTS-1:0][CW-1:0]   cnt;
  logic [SLOTS-1:0][WW-1:0]   last;
  logic [SLOTS-1:0][DICW-1:0] head;
  logic [SLOTS-1:0][PCW-1:0]  spc;

  logic                     depart, hit0, hit1, any_free, force_ev;
  logic [SLOTS-1:0]         joins, ripe, crit, free, done, newbit;
  logic [SLOTS-1:0][CW-1:0] cnt_n;
  logic [SLOTS-1:0]         mis_n;
  logic [SW-1:0]            ai, vi;
  logic [DICW-1:0]          best, age;

  assign depart = occ[wp];
  assign hit0   = in_src0_en && tv[in_src0] && !(depart && tag[in_src0] == wp);
  assign hit1   = in_src1_en && tv[in_src1] && !(depart && tag[in_src1] == wp);
  assign joins  = ((hit0 ? mem[tag[in_src0]] : '0) | (hit1 ? mem[tag[in_src1]] : '0)) & act;

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      cnt_n[s] = cnt[s] + CW'(joins[s]);
      mis_n[s] = mis[s] | (joins[s] & in_branch & in_mispred);
      ripe[s]  = act[s] && ((cnt_n[s] > SZ_LIM) ||
                            (depart && !joins[s] && last[s] == wp) ||
                            ((in_dic - head[s]) > DIST_LIM));
      crit[s]  = mis_n[s] || (cnt_n[s] > SZ_LIM);
    end
  end

  assign free = ~act | ripe;
  assign any_free = |free;

  always_comb begin
    ai = '0;
    for (int s = SLOTS - 1; s >= 0; s--)
      if (free[s]) ai = SW'(s);
    vi = '0;
    best = '0;
    for (int s = 0; s < SLOTS; s++) begin
      age = in_dic - head[s];
      if (act[s] && age >= best) begin
        best = age;
        vi = SW'(s);
      end
    end
  end

  assign force_ev = in_load && !any_free;
  assign done     = ripe | (force_ev ? (SLOTS'(1) << vi) : '0);
  assign newbit   = in_load ? (SLOTS'(1) << (any_free ? ai : vi)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      occ <= '0;
      tv <= '0;
      act <= '0;
      mis <= '0;
      out_valid <= '0;
      out_crit <= '0;
      out_pc <= '0;
      for (int j = 0; j < WIN; j++) mem[j] <= '0;
    end else begin
      out_valid <= in_valid ? done : '0;
      out_crit  <= in_valid ? (done & crit) : '0;
      if (in_valid) begin
        for (int s = 0; s < SLOTS; s++)
          if (done[s]) out_pc[s*PCW +: PCW] <= spc[s];
        for (int j = 0; j < WIN; j++) mem[j] <= mem[j] & ~done;
        mem[wp] <= (joins & ~done) | newbit;
        for (int r = 0; r < NREG; r++)
          if (depart && tag[r] == wp) tv[r] <= 1'b0;
        if (in_dst_en) begin
          tv[in_dst]  <= 1'b1;
          tag[in_dst] <= wp;
        end
        for (int s = 0; s < SLOTS; s++) begin
          if (newbit[s]) begin
            act[s]  <= 1'b1;
            cnt[s]  <= '0;
            mis[s]  <= 1'b0;
            last[s] <= wp;
            head[s] <= in_dic;
            spc[s]  <= in_pc;
          end else if (done[s]) begin
            act[s] <= 1'b0;
          end else if (act[s]) begin
            cnt[s] <= cnt_n[s];
            mis[s] <= mis_n[s];
            if (joins[s]) last[s] <= wp;
          end
        end
        occ[wp] <= 1'b1;
        wp <= (wp == WW'(WIN - 1)) ? '0 : wp + 1'b1;
      end
    end
  end
endmodule

// File: rtl/crit_load_tracker_chk.sv
module crit_load_tracker_chk #(
  parameter int SLOTS   = 4,
  parameter int DICW    = 32,
  parameter int CW      = 3,
  parameter int SIZE_TH = 5,
  parameter int DIST_TH = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_load,
  input logic [DICW-1:0]            in_dic,
  input logic [SLOTS-1:0]           out_valid,
  input logic [SLOTS-1:0]           out_crit,
  input logic [SLOTS-1:0]           act,
  input logic [SLOTS-1:0][CW-1:0]   cnt,
  input logic [SLOTS-1:0][DICW-1:0] head
);
  logic [DICW-1:0] last_dic;

  always_ff @(posedge clk) begin
    if (!rst_n) last_dic <= '0;
    else if (in_valid) last_dic <= in_dic;
  end

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (out_valid == '0));

  assert_crit_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_crit & ~out_valid) == '0);

  assert_load_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_load) |=> (act != '0));

  assert_force_emits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_load && (&act)) |=> (out_valid != '0));

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assert_size_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      act[s] |-> (int'(cnt[s]) <= SIZE_TH));
    assert_dist_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      act[s] |-> ((last_dic - head[s]) <= DICW'(DIST_TH)));
  end
endmodule

bind crit_load_tracker crit_load_tracker_chk #(
  .SLOTS(SLOTS), .DICW(DICW), .CW(CW), .SIZE_TH(SIZE_TH), .DIST_TH(DIST_TH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_load(in_load), .in_dic(in_dic),
  .out_valid(out_valid), .out_crit(out_crit), .act(act), .cnt(cnt), .head(head)
);

// File: tb/crit_load_tracker_tb.sv
`timescale 1ns/1ps
module crit_load_tracker_tb;
  localparam int WIN = 8, K = 4, NREG = 8, PCW = 32, DICW = 32, SZ = 5, DIST = 12;
  localparam int RW = $clog2(NREG);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_dst_en = 1'b0, in_src0_en = 1'b0, in_src1_en = 1'b0;
  logic [RW-1:0] in_dst = '0, in_src0 = '0, in_src1 = '0;
  logic in_load = 1'b0, in_branch = 1'b0, in_mispred = 1'b0;
  logic [PCW-1:0] in_pc = '0;
  logic [DICW-1:0] in_dic = '0;
  logic [K-1:0] out_valid, out_crit;
  logic [K*PCW-1:0] out_pc;

  always #2.5 clk = ~clk;

  crit_load_tracker #(.WIN(WIN), .SLOTS(K), .NREG(NREG), .PCW(PCW), .DICW(DICW),
                      .SIZE_TH(SZ), .DIST_TH(DIST)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst_en(in_dst_en), .in_dst(in_dst),
    .in_src0_en(in_src0_en), .in_src0(in_src0), .in_src1_en(in_src1_en), .in_src1(in_src1),
    .in_load(in_load), .in_branch(in_branch), .in_mispred(in_mispred), .in_pc(in_pc),
    .in_dic(in_dic), .out_valid(out_valid), .out_pc(out_pc), .out_crit(out_crit));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  string cur_lbl = "R1";
  logic [DICW-1:0] gdic = '0;

  // reference model state
  int m_wp;
  bit m_occ [WIN];
  bit [K-1:0] m_mem [WIN];
  bit m_tv [NREG];
  int m_tag [NREG];
  bit [K-1:0] m_act, m_mis;
  int m_cnt [K], m_last [K];
  logic [DICW-1:0] m_head [K];
  logic [PCW-1:0] m_pc [K];
  logic [K-1:0] exp_v, exp_c;
  logic [PCW-1:0] exp_pc [K];

  task automatic model_reset();
    m_wp = 0; m_act = '0; m_mis = '0;
    for (int j = 0; j < WIN; j++) begin m_occ[j] = 0; m_mem[j] = '0; end
    for (int r = 0; r < NREG; r++) begin m_tv[r] = 0; m_tag[r] = 0; end
    for (int s = 0; s < K; s++) begin m_cnt[s] = 0; m_last[s] = 0; m_head[s] = '0; m_pc[s] = '0; exp_pc[s] = '0; end
    exp_v = '0; exp_c = '0;
  endtask

  task automatic model_step(bit de, int d, bit e0, int a0, bit e1, int a1,
                            bit ld, bit br, bit mp, logic [PCW-1:0] pc, logic [DICW-1:0] dic);
    int w = m_wp;
    bit dep = m_occ[w];
    bit [K-1:0] jm = '0, mat = '0, cr = '0, nb = '0;
    int sel = -1;
    for (int r = 0; r < NREG; r++) if (dep && m_tv[r] && m_tag[r] == w) m_tv[r] = 0;
    if (e0 && m_tv[a0]) jm |= m_mem[m_tag[a0]];
    if (e1 && m_tv[a1]) jm |= m_mem[m_tag[a1]];
    jm &= m_act;
    for (int s = 0; s < K; s++) begin
      if (m_act[s]) begin
        int cn = m_cnt[s] + int'(jm[s]);
        bit mi = m_mis[s] | (jm[s] & br & mp);
        bit gone = dep && !jm[s] && m_last[s] == w;
        bit far = (dic - m_head[s]) > DICW'(DIST);
        if (cn > SZ || gone || far) begin
          mat[s] = 1; cr[s] = mi || (cn > SZ);
        end else begin
          m_cnt[s] = cn; m_mis[s] = mi;
          if (jm[s]) m_last[s] = w;
        end
      end
    end
    if (ld) begin
      for (int s = K - 1; s >= 0; s--) if (!m_act[s] || mat[s]) sel = s;
      if (sel < 0) begin
        logic [DICW-1:0] best = '0;
        for (int s = 0; s < K; s++)
          if ((dic - m_head[s]) >= best) begin best = dic - m_head[s]; sel = s; end
        mat[sel] = 1; cr[sel] = m_mis[sel];
      end
      nb[sel] = 1;
    end
    for (int s = 0; s < K; s++) if (mat[s]) exp_pc[s] = m_pc[s];
    for (int j = 0; j < WIN; j++) m_mem[j] &= ~mat;
    m_mem[w] = (jm & ~mat) | nb;
    m_act &= ~mat;
    if (ld) begin
      m_act[sel] = 1; m_cnt[sel] = 0; m_mis[sel] = 0; m_last[sel] = w;
      m_head[sel] = dic; m_pc[sel] = pc;
    end
    if (de) begin m_tv[d] = 1; m_tag[d] = w; end
    m_occ[w] = 1;
    m_wp = (w + 1) % WIN;
    exp_v = mat; exp_c = cr;
  endtask

  task automatic compare();
    bit bad = (out_valid !== exp_v) || (out_crit !== exp_c);
    for (int s = 0; s < K; s++)
      if (exp_v[s] && out_pc[s*PCW +: PCW] !== exp_pc[s]) bad = 1;
    n_cmp++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: valid=%b crit=%b pc0=%h | expected valid=%b crit=%b pc0=%h",
               cur_lbl, out_valid, out_crit, out_pc[PCW-1:0], exp_v, exp_c, exp_pc[0]);
    end
  endtask

  task automatic issue(string lbl, bit v, bit de, int d, bit e0, int a0, bit e1, int a1,
                       bit ld, bit br, bit mp);
    @(negedge clk);
    compare();
    cur_lbl = lbl;
    in_valid = v; in_dst_en = de; in_dst = RW'(d);
    in_src0_en = e0; in_src0 = RW'(a0); in_src1_en = e1; in_src1 = RW'(a1);
    in_load = ld; in_branch = br; in_mispred = mp;
    in_pc = 32'h4000_0000 | gdic; in_dic = gdic;
    if (v) begin
      model_step(de, d, e0, a0, e1, a1, ld, br, mp, in_pc, in_dic);
      gdic++;
    end else begin
      exp_v = '0; exp_c = '0;
    end
  endtask

  task automatic idle(string lbl); issue(lbl, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic fill(string lbl, int d); issue(lbl, 1, 1, d, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic load(string lbl, int d); issue(lbl, 1, 1, d, 0, 0, 0, 0, 1, 0, 0); endtask
  task automatic use1(string lbl, int d, int a); issue(lbl, 1, 1, d, 1, a, 0, 0, 0, 0, 0); endtask

  task automatic do_reset();
    @(negedge clk);
    compare();
    rst_n = 0; in_valid = 0;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1;
    cur_lbl = "R1";
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_lbl = "R1";
    idle("R10"); idle("R10");

    // R5: six dependents exceed the size limit
    do_reset(); load("R5", 1);
    for (int i = 0; i < 6; i++) use1("R5", 2, 1);
    idle("R5"); idle("R5");

    // R6: load with no dependents leaves the window
    do_reset(); load("R6", 1);
    for (int i = 0; i < 8; i++) fill("R6", 3);
    idle("R6");

    // R8: mispredicted branch member makes it critical
    do_reset(); load("R8", 1);
    issue("R8", 1, 0, 0, 1, 1, 0, 0, 0, 1, 1);
    for (int i = 0; i < 9; i++) fill("R8", 4);
    idle("R8");

    // R7: sparse dependents keep it in the window until the distance rule fires
    do_reset(); load("R7", 1);
    for (int k = 1; k <= 14; k++) begin
      if (k % 3 == 0) use1("R7", 2, 1); else fill("R7", 4);
      if (k == 5) idle("R10");
    end
    idle("R7");

    // R2: a non-member overwrites the register, later readers stay out
    do_reset(); load("R2", 1); fill("R2", 1);
    for (int i = 0; i < 8; i++) use1("R2", 2, 1);
    idle("R2");

    // R3 R4: two loads, a consumer of both, then transitive dependents
    do_reset(); load("R3 R4", 1); load("R3 R4", 2);
    issue("R3", 1, 1, 3, 1, 1, 1, 2, 0, 0, 0);
    for (int i = 0; i < 5; i++) use1("R3", 3, 3);
    idle("R3");

    // R9: five loads, the fifth forces out the oldest
    do_reset();
    for (int i = 1; i <= 5; i++) load("R9", i);
    idle("R9");

    // R11: register tag invalidated when its writer's slot is reused
    do_reset(); load("R11", 1);
    for (int i = 0; i < 7; i++) fill("R11", 6);
    load("R11", 2);
    for (int i = 0; i < 6; i++) use1("R11", 3, 1);
    for (int i = 0; i < 3; i++) fill("R11", 6);
    idle("R11");

    // random mix
    do_reset();
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom % 4) != 0;
      bit br = ($urandom % 7) == 0;
      bit ld = !br && (($urandom % 4) == 0);
      issue("random", v, !br && (($urandom % 5) != 0), int'($urandom % NREG),
            ($urandom % 10) < 7, int'($urandom % NREG),
            ($urandom % 10) < 5, int'($urandom % NREG), ld, br, br && ($urandom % 2));
    end
    idle("R10");
    @(negedge clk);
    compare();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule